// File: doc/BRIEF.md
# Space Vector Modulation Sequencer

This block turns a reference voltage vector, given as an angle and a normalized magnitude, into the three upper-switch states of a two-level three-phase bridge. The angle selects one of six 60-degree sectors and an in-sector angle. From these values the block computes how long to apply the two active vectors that bound the sector. The zero-vector time is whatever remains of the switching period. Within each period the block then plays a symmetric seven-segment pattern: zero, first active, second active, all-on, second active, first active, zero.

The period length is given in clock cycles. A strobe captures a new angle and magnitude. The first strobe after reset starts modulation. Later strobes are only staged, and the staged values are applied at the next period boundary, so a period in progress is never altered. Dead time and coordinate transforms are handled elsewhere. The lower switches are the complements of the outputs.

Top module: `svm_modulator`

## Requirements
- R1: After reset and until the first strobe, the leg outputs are 000, the sector output is 0 and the segment index is 0.
- R2: A strobe captures angle and magnitude. While modulation is running, the captured values and the current period input take effect only at the start of the next period. A strobe on the cycle where a period ends is used at once.
- R3: The angle has GAM_W+3 bits. Its top three bits h select sector h+1 for h in 0..5, sector 1 for h=6 and sector 2 for h=7. The low GAM_W bits give the in-sector angle γ in steps of 60/2^GAM_W degrees.
- R4: Segment index 0..6 shows, in this order: V0, A, B, V7, B, A, V0. Legs are {a,b,c}, with V0=000, V7=111, V1=100, V2=110, V3=010, V4=011, V5=001 and V6=101. For sector k, in odd sectors A=Vk and B=Vk+1 (V6 is followed by V1). In even sectors the two are swapped.
- R5: Within a period, a step to the next adjacent segment index changes at most one leg.
- R6: With m = magnitude/2^(MAG_W-1) and P the period, the time on Vk is P·m·sin(60°−γ) and the time on the following vector is P·m·sin(γ), each within two cycles.
- R7: Each active time is split into two halves that differ by at most one cycle. Each V0 segment lasts floor(T0/4) cycles, and the two V0 segments are equal. V7 takes the rest of T0.
- R8: Segments of zero length are skipped. At zero magnitude, no active vector appears.
- R9: If the two active times together exceed P, both are scaled in proportion so that they fill P, and neither V0 nor V7 appears.
- R10: Each period lasts exactly the period value sampled at its start. That value must be at least 8.
- R11: The sector output changes only at a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Switching period in clock cycles |
| angle_i | input | GAM_W+3 | Reference angle: sector field and in-sector angle |
| mag_i | input | MAG_W | Reference magnitude, unity at 2^(MAG_W-1) |
| upd_i | input | 1 | Strobe that captures angle and magnitude |
| legs_o | output | 3 | Upper-switch states {a,b,c} |
| sector_o | output | 3 | Sector in use, 1..6; 0 while idle |
| seg_o | output | 3 | Segment index 0..6 in the current period |

## Verification
The hardest behaviour to reach is a strobe that arrives in the middle of a period. The bench must show that the strobe leaves the running pattern untouched and still takes effect at the next boundary. The stimulus issues two strobes a few cycles apart, both inside one period, and checks every clock against a model that applies staged values only when it sees a new period begin. Skipped segments and proportional scaling are reached with zero magnitude, near-full magnitude at mid-sector, and full magnitude at a sector edge. The last of these leaves only the first active vector for the whole period.

// File: rtl/svm_pkg.sv
package svm_pkg;
  localparam int NUM_SEG = 7;
  localparam int SEG_W   = 3;
  localparam logic [SEG_W-1:0] SEG_ZERO7 = 3'd3;

  // upper-switch pattern {a,b,c} of active vector k (1..6)
  function automatic logic [2:0] act_vec(input logic [2:0] k);
    case (k)
      3'd1:    act_vec = 3'b100;
      3'd2:    act_vec = 3'b110;
      3'd3:    act_vec = 3'b010;
      3'd4:    act_vec = 3'b011;
      3'd5:    act_vec = 3'b001;
      3'd6:    act_vec = 3'b101;
      default: act_vec = 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] sec_next(input logic [2:0] k);
    sec_next = (k == 3'd6) ? 3'd1 : k + 3'd1;
  endfunction
endpackage

// File: rtl/svm_sine.sv
module svm_sine #(
  parameter int GAM_W = 8
) (
  input  logic [GAM_W:0] g_i,   // 0 .. 2^GAM_W spans 0 .. 60 degrees
  output logic [15:0]    sin_o  // Q16
);
  localparam logic [63:0] K_RAD  = 64'd68629; // pi/3 in Q16
  localparam logic [63:0] INV6   = 64'd10923; // 1/6 in Q16
  localparam logic [63:0] INV120 = 64'd546;   // 1/120 in Q16

  logic [63:0] x, x2, x3, x5, s;

  // odd series to fifth order; error well below one LSB of the dwell counts
  always_comb begin
    x     = (64'(g_i) * K_RAD) >> GAM_W;
    x2    = (x * x) >> 16;
    x3    = (x2 * x) >> 16;
    x5    = (x3 * x2) >> 16;
    s     = x - ((x3 * INV6) >> 16) + ((x5 * INV120) >> 16);
    sin_o = s[15:0];
  end
endmodule

// File: rtl/svm_dwell.sv
module svm_dwell import svm_pkg::*; #(
  parameter int CNT_W = 12,
  parameter int MAG_W = 10,
  parameter int GAM_W = 8
) (
  input  logic [GAM_W+2:0]                    angle_i,
  input  logic [MAG_W-1:0]                    mag_i,
  input  logic [CNT_W-1:0]                    period_i,
  output logic [2:0]                          sector_o,
  output logic [2:0]                          vec_a_o,
  output logic [2:0]                          vec_b_o,
  output logic [NUM_SEG-1:0][CNT_W-1:0]       lens_o
);
  localparam int SH = MAG_W - 1 + 16;
  localparam logic [GAM_W:0] GAM_FULL = {1'b1, {GAM_W{1'b0}}};

  logic [2:0]             hi;
  logic [GAM_W-1:0]       gam;
  logic [1:0][GAM_W:0]    gin;
  logic [1:0][15:0]       sn;
  logic                   odd;

  assign hi  = angle_i[GAM_W+2 -: 3];
  assign gam = angle_i[GAM_W-1:0];
  assign sector_o = (hi >= 3'd6) ? hi - 3'd5 : hi + 3'd1;
  assign odd = sector_o[0];

  assign gin[0] = {1'b0, gam};            // gamma -> second bounding vector
  assign gin[1] = GAM_FULL - {1'b0, gam}; // 60 - gamma -> first bounding vector

  for (genvar i = 0; i < 2; i++) begin : g_sin
    svm_sine #(.GAM_W(GAM_W)) i_sine (.g_i(gin[i]), .sin_o(sn[i]));
  end

  assign vec_a_o = odd ? act_vec(sector_o) : act_vec(sec_next(sector_o));
  assign vec_b_o = odd ? act_vec(sec_next(sector_o)) : act_vec(sector_o);

  logic [63:0] p, t1, t2, sum, t1s, t2s, t0, ta, tb, z0, z7;

  always_comb begin
    p   = 64'(period_i);
    t1  = (p * 64'(mag_i) * 64'(sn[1])) >> SH;
    t2  = (p * 64'(mag_i) * 64'(sn[0])) >> SH;
    sum = t1 + t2;
    if (sum > p) begin
      t1s = (t1 * p) / sum;
      t2s = p - t1s;
      t0  = '0;
    end else begin
      t1s = t1;
      t2s = t2;
      t0  = p - sum;
    end
    ta = odd ? t1s : t2s;
    tb = odd ? t2s : t1s;
    z0 = t0 >> 2;
    z7 = t0 - (z0 << 1);
    lens_o[0] = CNT_W'(z0);
    lens_o[1] = CNT_W'(ta >> 1);
    lens_o[2] = CNT_W'(tb >> 1);
    lens_o[3] = CNT_W'(z7);
    lens_o[4] = CNT_W'(tb - (tb >> 1));
    lens_o[5] = CNT_W'(ta - (ta >> 1));
    lens_o[6] = CNT_W'(z0);
  end
endmodule

// File: rtl/svm_player.sv
module svm_player import svm_pkg::*; #(
  parameter int CNT_W = 12
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            upd_i,
  input  logic [NUM_SEG-1:0][CNT_W-1:0]   lens_i,
  input  logic [2:0]                      sector_i,
  input  logic [2:0]                      vec_a_i,
  input  logic [2:0]                      vec_b_i,
  output logic [2:0]                      legs_o,
  output logic [2:0]                      sector_o,
  output logic [SEG_W-1:0]                seg_o
);
  logic                          run_q;
  logic [SEG_W-1:0]              seg_q;
  logic [CNT_W-1:0]              tmr_q;
  logic [2:0]                    sec_q, va_q, vb_q;
  logic [NUM_SEG-1:0][CNT_W-1:0] lens_q;

  logic             nxt_hit, last_cyc, load;
  logic [SEG_W-1:0] nxt_idx, first_idx;

  // next non-empty segment of this period, first non-empty of the new one
  always_comb begin
    nxt_hit   = 1'b0;
    nxt_idx   = '0;
    first_idx = '0;
    for (int j = NUM_SEG - 1; j >= 0; j--) begin
      if (SEG_W'(j) > seg_q && lens_q[j] != '0) begin
        nxt_hit = 1'b1;
        nxt_idx = SEG_W'(j);
      end
      if (lens_i[j] != '0) first_idx = SEG_W'(j);
    end
  end

  assign last_cyc = run_q && (tmr_q == CNT_W'(1));
  assign load     = (!run_q && upd_i) || (last_cyc && !nxt_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      seg_q  <= '0;
      tmr_q  <= '0;
      sec_q  <= '0;
      va_q   <= '0;
      vb_q   <= '0;
      lens_q <= '0;
    end else if (load) begin
      run_q  <= 1'b1;
      lens_q <= lens_i;
      seg_q  <= first_idx;
      tmr_q  <= lens_i[first_idx];
      sec_q  <= sector_i;
      va_q   <= vec_a_i;
      vb_q   <= vec_b_i;
    end else if (last_cyc) begin
      seg_q <= nxt_idx;
      tmr_q <= lens_q[nxt_idx];
    end else if (run_q) begin
      tmr_q <= tmr_q - CNT_W'(1);
    end
  end

  always_comb begin
    case (seg_q)
      3'd0, 3'd6: legs_o = 3'b000;
      SEG_ZERO7:  legs_o = 3'b111;
      3'd1, 3'd5: legs_o = va_q;
      default:    legs_o = vb_q;
    endcase
  end

  assign sector_o = sec_q;
  assign seg_o    = seg_q;

  p_idle_v0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (legs_o == 3'b000 && sec_q == 3'd0));

  // R5: adjacent-segment steps inside a period flip at most one leg
  p_one_leg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_cyc && nxt_hit && nxt_idx == seg_q + 3'd1) |=>
      ($countones(legs_o ^ $past(legs_o)) <= 1));

  p_sector_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !load) |=> $stable(sec_q));

  p_timer_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (tmr_q != '0));

  p_seg_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_cyc && !load) |=> (seg_q > $past(seg_q)));

  p_seg_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_q <= 3'd6);
endmodule

// File: rtl/svm_modulator.sv
module svm_modulator import svm_pkg::*; #(
  parameter int CNT_W = 12,
  parameter int MAG_W = 10,
  parameter int GAM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [GAM_W+2:0] angle_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             upd_i,
  output logic [2:0]       legs_o,
  output logic [2:0]       sector_o,
  output logic [2:0]       seg_o
);
  localparam int ANG_W = GAM_W + 3;
  localparam int SUM_W = CNT_W + 3;

  logic [ANG_W-1:0] stg_ang, src_ang;
  logic [MAG_W-1:0] stg_mag, src_mag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_ang <= '0;
      stg_mag <= '0;
    end else if (upd_i) begin
      stg_ang <= angle_i;
      stg_mag <= mag_i;
    end
  end

  // bypass so a strobe on a boundary cycle is used immediately
  assign src_ang = upd_i ? angle_i : stg_ang;
  assign src_mag = upd_i ? mag_i   : stg_mag;

  logic [2:0]                    calc_sec, vec_a, vec_b;
  logic [NUM_SEG-1:0][CNT_W-1:0] lens;

  svm_dwell #(.CNT_W(CNT_W), .MAG_W(MAG_W), .GAM_W(GAM_W)) i_dwell (
    .angle_i  (src_ang),
    .mag_i    (src_mag),
    .period_i (period_i),
    .sector_o (calc_sec),
    .vec_a_o  (vec_a),
    .vec_b_o  (vec_b),
    .lens_o   (lens)
  );

  svm_player #(.CNT_W(CNT_W)) i_player (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd_i),
    .lens_i   (lens),
    .sector_i (calc_sec),
    .vec_a_i  (vec_a),
    .vec_b_i  (vec_b),
    .legs_o   (legs_o),
    .sector_o (sector_o),
    .seg_o    (seg_o)
  );

  logic [SUM_W-1:0] lens_sum;
  always_comb begin
    lens_sum = '0;
    for (int j = 0; j < NUM_SEG; j++) lens_sum += SUM_W'(lens[j]);
  end

  p_len_sum_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lens_sum == SUM_W'(period_i));

  p_sector_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (calc_sec >= 3'd1 && calc_sec <= 3'd6));
endmodule

// File: tb/test_svm_modulator.sv
module test_svm_modulator;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int MAG_W = 10;
  localparam int GAM_W = 8;
  localparam real PI = 3.14159265358979;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] period_i = '0;
  logic [GAM_W+2:0] angle_i = '0;
  logic [MAG_W-1:0] mag_i = '0;
  logic             upd_i = 1'b0;
  logic [2:0]       legs_o, sector_o, seg_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  svm_modulator #(.CNT_W(CNT_W), .MAG_W(MAG_W), .GAM_W(GAM_W)) i_svm_modulator (
    .clk_i, .rst_ni, .period_i, .angle_i, .mag_i, .upd_i, .legs_o, .sector_o, .seg_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0.2f expected %0.2f (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] vtab(input int k);
    case (k)
      1: return 3'b100;  2: return 3'b110;  3: return 3'b010;
      4: return 3'b011;  5: return 3'b001;  6: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  // behavioural model state
  bit run_m, have_per, p_upd, newp;
  int st_ang, st_mag, p_ang, p_mag, p_per;
  int e_sec, e_p, e_mag, last_seg;
  real e_a, e_b, e_t0;
  bit e_over;
  logic [2:0] e_va, e_vb, last_legs, exp_legs;
  int cnt[7];

  task automatic start_period(input int ang, input int mag, input int per);
    int hi, g;
    real gam, m, t1, t2, sc;
    hi = ang >> GAM_W;
    g  = ang % (1 << GAM_W);
    e_sec = (hi < 6) ? hi + 1 : hi - 5;
    gam = real'(g) / real'(1 << GAM_W) * PI / 3.0;
    m   = real'(mag) / real'(1 << (MAG_W - 1));
    t1  = per * m * $sin(PI / 3.0 - gam);
    t2  = per * m * $sin(gam);
    e_over = (t1 + t2) > per * 1.02;
    if (t1 + t2 > per) begin
      sc = per / (t1 + t2);
      t1 = t1 * sc;
      t2 = t2 * sc;
    end
    e_t0 = per - t1 - t2;
    if (e_t0 < 0.0) e_t0 = 0.0;
    if (e_sec % 2 == 1) begin
      e_a = t1; e_b = t2; e_va = vtab(e_sec); e_vb = vtab(e_sec % 6 + 1);
    end else begin
      e_a = t2; e_b = t1; e_va = vtab(e_sec % 6 + 1); e_vb = vtab(e_sec);
    end
    e_p = per;
    e_mag = mag;
    for (int i = 0; i < 7; i++) cnt[i] = 0;
  endtask

  task automatic finish_period();
    int tot;
    tot = 0;
    for (int i = 0; i < 7; i++) tot += cnt[i];
    chk(tot == e_p, "R10 period length", tot, e_p);
    chk(absr(cnt[1] + cnt[5] - e_a) <= 2.0, "R6 first active time (R2 staging)", cnt[1] + cnt[5], e_a);
    chk(absr(cnt[2] + cnt[4] - e_b) <= 2.0, "R6 second active time (R2 staging)", cnt[2] + cnt[4], e_b);
    chk(cnt[0] == cnt[6], "R7 equal V0 segments", cnt[6], cnt[0]);
    chk(absr(cnt[0] - e_t0 / 4.0) <= 2.0, "R7 V0 share", cnt[0], e_t0 / 4.0);
    chk(absr(cnt[3] - e_t0 / 2.0) <= 3.0, "R7 V7 share", cnt[3], e_t0 / 2.0);
    chk(absr(cnt[1] - cnt[5]) <= 1.0, "R7 first active halves", cnt[1], cnt[5]);
    chk(absr(cnt[2] - cnt[4]) <= 1.0, "R7 second active halves", cnt[2], cnt[4]);
    if (e_over) chk(cnt[0] + cnt[3] + cnt[6] == 0, "R9 no zero vectors", cnt[0] + cnt[3] + cnt[6], 0);
    if (e_mag == 0) chk(cnt[1] + cnt[2] + cnt[4] + cnt[5] == 0, "R8 actives skipped", cnt[1] + cnt[2] + cnt[4] + cnt[5], 0);
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      run_m = 0; have_per = 0; st_ang = 0; st_mag = 0; last_seg = 0;
    end else begin
      newp = 0;
      if (!run_m && p_upd) newp = 1;
      else if (run_m && int'(seg_o) < last_seg) newp = 1;
      if (newp) begin
        if (have_per) finish_period();
        start_period(p_upd ? p_ang : st_ang, p_upd ? p_mag : st_mag, p_per);
        run_m = 1;
        have_per = 1;
      end
      if (p_upd) begin st_ang = p_ang; st_mag = p_mag; end
      if (!run_m) begin
        chk(legs_o == 3'b000 && sector_o == 3'd0 && seg_o == 3'd0, "R1 idle outputs",
            {legs_o, sector_o, seg_o}, 0);
      end else begin
        case (seg_o)
          3'd0, 3'd6: exp_legs = 3'b000;
          3'd3:       exp_legs = 3'b111;
          3'd1, 3'd5: exp_legs = e_va;
          default:    exp_legs = e_vb;
        endcase
        chk(legs_o == exp_legs, "R4 vector of segment", legs_o, exp_legs);
        chk(int'(sector_o) == e_sec, "R3 R11 sector", sector_o, e_sec);
        if (!newp && int'(seg_o) == last_seg + 1)
          chk($countones(legs_o ^ last_legs) <= 1, "R5 one leg per step",
              $countones(legs_o ^ last_legs), 1);
        if (seg_o <= 3'd6) cnt[seg_o]++;
        last_seg = int'(seg_o);
        last_legs = legs_o;
      end
    end
    p_upd = upd_i; p_ang = int'(angle_i); p_mag = int'(mag_i); p_per = int'(period_i);
  end

  task automatic send(input int ang, input int mag, input int per);
    @(posedge clk_i); #1;
    angle_i = (GAM_W+3)'(ang);
    mag_i = MAG_W'(mag);
    period_i = CNT_W'(per);
    upd_i = 1'b1;
    @(posedge clk_i); #1;
    upd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    idle(6);                                 // R1 idle window
    send(0 * 256 + 128, 256, 64);  idle(200);
    for (int s = 0; s < 6; s++) begin        // R3 R4 every sector
      send(s * 256 + 40 + s * 30, 410, 80 + s * 8);
      idle(3 * (80 + s * 8));
    end
    send(6 * 256 + 100, 300, 72);  idle(220); // R3 wrap to sector 1
    send(7 * 256 + 200, 300, 72);  idle(220); // R3 wrap to sector 2
    send(3 * 256, 0, 64);          idle(200); // R8 zero magnitude
    send(2 * 256 + 128, 1023, 96); idle(300); // R9 scaled mid-sector
    send(0 * 256 + 0, 1023, 64);   idle(200); // R9 sector edge, single vector
    send(4 * 256 + 255, 512, 100); idle(300);
    send(5 * 256 + 10, 600, 60);   idle(130);
    send(1 * 256 + 50, 300, 90);   idle(20);  // R2 two strobes inside one period
    send(4 * 256 + 70, 700, 90);   idle(8);
    send(3 * 256 + 200, 450, 110); idle(330);
    @(posedge clk_i); #1 period_i = CNT_W'(50);  // R10 new period without strobe
    idle(200);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule